// File: doc/BRIEF.md
# Next Instruction Address Selector

This block works out the address of the next instruction for a 32-bit processor with fixed 4-byte instructions. It takes the current fetch address, the 16-bit signed branch displacement, the 26-bit jump field, the two register operands that a conditional branch compares, and three select lines. From these it produces the next fetch address in the same cycle. It holds no state.

Branches are PC-relative. The displacement counts whole instructions, so it is sign-extended, scaled by four and added to the address of the following instruction. Jumps are pseudo-direct. The 26-bit field, scaled by four, replaces the low 28 bits, and the top four bits come from the address of the following instruction. A jump therefore stays inside its 256 MB region. The block contains the operand equality comparator and both target adders. Fetch, the register file and pipeline flushing are handled outside it.

Top module: `next_pc_sel`

## Requirements
- R1: With no select asserted, or with a branch select whose condition fails, `npc_o` equals `pc_i + 4`.
- R2: With `sel_beq_i` set, `sel_jmp_i` clear and `opa_i == opb_i`, `npc_o` equals `pc_i + 4 + (sign-extended br_imm_i << 2)`.
- R3: With `sel_bne_i` set, `sel_jmp_i` clear and `opa_i != opb_i`, `npc_o` equals the same branch target as in R2.
- R4: `br_imm_i` is two's complement with bit 15 as its sign. A taken branch with `br_imm_i = 16'hFFFF` gives `npc_o == pc_i`. A taken branch with `16'h8000` gives `pc_i + 4 - 131072`.
- R5: With `sel_jmp_i` set, `npc_o` equals `{(pc_i+4)[31:28], jmp_field_i, 2'b00}`. Near a region boundary, the region comes from `pc_i + 4` and not from `pc_i`.
- R6: `sel_jmp_i` takes priority over both branch selects, whatever the state of the operands.
- R7: With both branch selects set and no jump, exactly one of the two conditions holds, so the branch target is always taken.
- R8: Every address sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current instruction address |
| br_imm_i | input | 16 | Signed branch displacement in instructions |
| jmp_field_i | input | 26 | Jump target field |
| opa_i | input | 32 | First compared register operand |
| opb_i | input | 32 | Second compared register operand |
| sel_beq_i | input | 1 | Branch if operands are equal |
| sel_bne_i | input | 1 | Branch if operands differ |
| sel_jmp_i | input | 1 | Unconditional jump |
| npc_o | output | 32 | Next instruction address |

## Verification
All results are combinational, so each is due in the same cycle its inputs change and no register delay applies. The bench drives each vector just after a falling clock edge and samples `npc_o` one nanosecond later, well away from the rising edge. The sweep covers every select combination, equal and unequal operands, displacements at both extremes and zero, and addresses that wrap or cross a 256 MB region. Each expected address is built in the bench from integer arithmetic on the inputs.

// File: rtl/next_pc_sel.sv
module next_pc_sel #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JF_W  = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] br_imm_i,
  input  logic [JF_W-1:0]  jmp_field_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic             sel_beq_i,
  input  logic             sel_bne_i,
  input  logic             sel_jmp_i,
  output logic [XLEN-1:0]  npc_o
);

  localparam int REGION_W = XLEN - JF_W - 2;
  localparam int EXT_W    = XLEN - IMM_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] br_addr;
  logic [XLEN-1:0] jmp_addr;
  logic            same;
  logic            take_br;

  assign seq_addr = pc_i + STEP;
  assign disp     = {{EXT_W{br_imm_i[IMM_W-1]}}, br_imm_i, 2'b00};
  assign br_addr  = seq_addr + disp;
  assign jmp_addr = {seq_addr[XLEN-1 -: REGION_W], jmp_field_i, 2'b00};
  assign same     = (opa_i == opb_i);
  assign take_br  = (sel_beq_i & same) | (sel_bne_i & ~same);

  always_comb begin
    if (sel_jmp_i)     npc_o = jmp_addr;
    else if (take_br)  npc_o = br_addr;
    else               npc_o = seq_addr;
  end

  always_comb begin
    if (!sel_jmp_i && !sel_beq_i && !sel_bne_i)
      p_fallthrough_r1: assert (npc_o == seq_addr);
    if (sel_jmp_i)
      p_jump_region_r5: assert (npc_o[XLEN-1 -: REGION_W] == seq_addr[XLEN-1 -: REGION_W]
                                && npc_o[1:0] == 2'b00);
    if (sel_jmp_i && (sel_beq_i || sel_bne_i))
      p_jump_wins_r6: assert (npc_o == jmp_addr);
    if (!sel_jmp_i && sel_beq_i && sel_bne_i)
      p_both_taken_r7: assert (npc_o == br_addr);
    if (!sel_jmp_i && take_br && (&br_imm_i))
      p_self_loop_r4: assert (npc_o == pc_i);
    if (!sel_jmp_i)
      p_low_bits_r2: assert (npc_o[1:0] == pc_i[1:0]);
  end

endmodule

// File: tb/sim_next_pc_sel.sv
module sim_next_pc_sel;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] pc, opa, opb, npc;
  logic [15:0] imm;
  logic [25:0] jf;
  logic beq, bne, jmp;
  int n_chk = 0;
  int n_fail = 0;

  next_pc_sel u0 (
    .pc_i(pc), .br_imm_i(imm), .jmp_field_i(jf), .opa_i(opa), .opb_i(opb),
    .sel_beq_i(beq), .sel_bne_i(bne), .sel_jmp_i(jmp), .npc_o(npc)
  );

  task automatic run_vec(input logic [31:0] p, input logic [15:0] im, input logic [25:0] f,
                         input logic eqop, input logic [2:0] sel);
    longint exp_l;
    logic [31:0] exp;
    logic taken;
    string tag;
    @(negedge clk);
    pc = p; imm = im; jf = f; opa = 32'h1234_5678;
    opb = eqop ? 32'h1234_5678 : 32'h1234_5679;
    jmp = sel[2]; bne = sel[1]; beq = sel[0];
    #1;
    taken = (beq && eqop) || (bne && !eqop);
    if (jmp) begin
      exp_l = longint'(p) + 4;
      exp = (32'(exp_l) & 32'hF000_0000) | {4'h0, f, 2'b00};
      tag = (beq || bne) ? "R6" : "R5";
    end else if (taken) begin
      exp_l = longint'(p) + 4 + longint'($signed(im)) * 4;
      exp = 32'(exp_l);
      if (beq && bne) tag = "R7";
      else if (im[15]) tag = "R4";
      else if (exp_l > 64'hFFFF_FFFF) tag = "R8";
      else tag = beq ? "R2" : "R3";
    end else begin
      exp_l = longint'(p) + 4;
      exp = 32'(exp_l);
      tag = (exp_l > 64'hFFFF_FFFF) ? "R8" : "R1";
    end
    n_chk++;
    if (npc !== exp) begin
      n_fail++;
      $display("FAIL %s pc=%h imm=%h jf=%h sel=%b eq=%b got=%h exp=%h",
               tag, p, im, f, sel, eqop, npc, exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] pcs [6];
    logic [15:0] imms [6];
    logic [25:0] jfs [3];
    pcs[0] = 32'h0040_0024; pcs[1] = 32'h0FFF_FFFC; pcs[2] = 32'hFFFF_FFFC;
    pcs[3] = 32'h0000_0000; pcs[4] = 32'h7FFF_FFF8; pcs[5] = 32'hEFFF_FFF8;
    imms[0] = 16'h0000; imms[1] = 16'hFFFF; imms[2] = 16'h7FFF;
    imms[3] = 16'h8000; imms[4] = 16'h0002; imms[5] = 16'hFFF9;
    jfs[0] = 26'h0000000; jfs[1] = 26'h3FFFFFF; jfs[2] = 26'h0100009;
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 3; c++)
          for (int e = 0; e < 2; e++)
            for (int s = 0; s < 8; s++)
              run_vec(pcs[a], imms[b], jfs[c], e[0], s[2:0]);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule